// File: doc/BRIEF.md
# Regulator Fault Tally and Shutdown Arbiter

This block sits beside the power sequencer of a multi-rail regulator controller. It watches per-rail undervoltage and overcurrent flags and turns each new fault into a disable bit for that rail alone. It keeps a running tally of fault events. Once the tally reaches a threshold it latches a global shutdown. The threshold is lower while the controller is coming back from the deepest sleep state. While any rail is held off, the block raises a retry request. The sequencer then releases the faulted rails in one step through its normal startup order, and rails that are still regulating are not touched.

Some rails are supplied by another rail. When a supplying rail is disabled, the rail it feeds loses its input and is counted as a fault of its own one cycle later. A decay timer runs on the switching clock while the tally is non-zero. After 16384 quiet cycles, which is eight soft-start cycles, it forgets all earlier faults. The tally and the shutdown latch clear only on reset or on the sequencer's deep-sleep clear.

Top module: `fault_supervisor`

## Requirements
- R1: After reset, or in the cycle after `s5_clear` is high, `rail_disable` is all zeros and `retry_req` and `shutdown` are low.
- R2: A high `uv_flag[i]` or `oc_flag[i]` on an enabled rail sets `rail_disable[i]` at the next edge and leaves every other bit alone. Both flags of one rail high in the same cycle make one event.
- R3: Flags on a rail whose disable bit is already set add nothing to the tally, however long they stay high.
- R4: Rail 1 is fed from rail 0. One cycle after `rail_disable[0]` rises, `rail_disable[1]` also rises, and that counts as a separate event.
- R5: Events on several rails in the same cycle each add one to the tally.
- R6: With `restart_s5` low, `shutdown` rises at the same edge that brings the tally to 5.
- R7: With `restart_s5` high, `shutdown` rises at the same edge that brings the tally to 4.
- R8: An event 16383 cycles after the previous one still adds to the old tally. An event 16385 cycles after it finds the tally already cleared to zero.
- R9: `retry_req` is high while any rail is disabled and shutdown is low. A one-cycle `retry_go` clears every set disable bit and leaves the tally unchanged.
- R10: While `shutdown` is high, `rail_disable` is all ones and `retry_req` is low. Flags and `retry_go` have no effect, and only `s5_clear` or reset releases the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching-rate clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| s5_clear | input | 1 | Sequencer clear on entry to deepest sleep |
| restart_s5 | input | 1 | High while restarting from deepest sleep; selects the lower threshold |
| retry_go | input | 1 | One-cycle release of all faulted rails |
| uv_flag | input | 5 | Per-rail undervoltage flags |
| oc_flag | input | 5 | Per-rail overcurrent flags |
| rail_disable | output | 5 | Per-rail disable, 1 = rail held off |
| retry_req | output | 1 | Faulted rails are waiting for a restart |
| shutdown | output | 1 | Global shutdown latch |

## Verification
The tally is exercised with single-rail faults, faults on several rails in the same cycle, a flag held high on a rail that is already off, and a supplying-rail fault that drags its dependent rail down. Each pattern is built so that a design counting events the wrong way reaches or misses the threshold at a different edge. Repeated faults with retries in between show that a release keeps the tally. Faults placed one cycle inside and one cycle outside the quiet window separate a working decay timer from an off-by-one timer. The same fault sequence is run with and without the restart flag to show that the two thresholds differ.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    typedef enum logic [1:0] {
        TL_IDLE  = 2'd0,
        TL_ARMED = 2'd1,
        TL_DOWN  = 2'd2
    } tally_e;

    function automatic logic [7:0] pop32(input logic [31:0] v);
        logic [7:0] n;
        n = '0;
        for (int k = 0; k < 32; k++) begin
            n = n + {7'd0, v[k]};
        end
        return n;
    endfunction

endpackage

// File: rtl/fsup_event_gen.sv
module fsup_event_gen #(
    parameter int NUM_RAILS = 5,
    parameter int FEED_SRC [NUM_RAILS] = '{0, 0, 2, 3, 4}
) (
    input  logic                 active,
    input  logic [NUM_RAILS-1:0] uv_flag,
    input  logic [NUM_RAILS-1:0] oc_flag,
    input  logic [NUM_RAILS-1:0] dis_q,
    output logic [NUM_RAILS-1:0] ev
);
    logic [NUM_RAILS-1:0] raw;

    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
        localparam int SRC = FEED_SRC[i];
        if (SRC == i) begin : g_root
            assign raw[i] = ~dis_q[i] & (uv_flag[i] | oc_flag[i]);
        end else begin : g_fed
            // losing the supplying rail counts as this rail's own fault
            assign raw[i] = ~dis_q[i] & (uv_flag[i] | oc_flag[i] | dis_q[SRC]);
        end
    end

    assign ev = raw & {NUM_RAILS{active}};
endmodule

// File: rtl/fsup_rail_latch.sv
module fsup_rail_latch #(
    parameter int NUM_RAILS = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 release_all,
    input  logic [NUM_RAILS-1:0] ev,
    output logic [NUM_RAILS-1:0] dis_q
);
    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                dis_q[i] <= 1'b0;
            end else if (ev[i]) begin
                dis_q[i] <= 1'b1;
            end else if (release_all) begin
                dis_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fsup_tally.sv
module fsup_tally #(
    parameter int NUM_RAILS    = 5,
    parameter int QUIET_CYCLES = 16384,
    parameter int LIM_RESTART  = 4,
    parameter int LIM_NORMAL   = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 restart_s5,
    input  logic [NUM_RAILS-1:0] ev,
    output logic                 shutdown
);
    import fsup_pkg::*;

    localparam int CNT_W = $clog2(LIM_NORMAL + NUM_RAILS + 1);
    localparam int TMR_W = $clog2(QUIET_CYCLES);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(QUIET_CYCLES - 1);

    typedef struct packed {
        tally_e             st;
        logic [CNT_W-1:0]   cnt;
        logic [TMR_W-1:0]   tmr;
    } tally_t;

    tally_t     q, d;
    logic [7:0] sum;
    logic [7:0] limit;

    always_comb begin
        sum   = 8'(q.cnt) + pop32(32'(ev));
        limit = restart_s5 ? 8'(LIM_RESTART) : 8'(LIM_NORMAL);
        d     = q;
        case (q.st)
            TL_DOWN: ;
            default: begin
                if (|ev) begin
                    d.cnt = CNT_W'(sum);
                    d.tmr = '0;
                    d.st  = (sum >= limit) ? TL_DOWN : TL_ARMED;
                end else if (q.st == TL_ARMED) begin
                    if (q.tmr == TMR_LAST) begin
                        d.cnt = '0;
                        d.tmr = '0;
                        d.st  = TL_IDLE;
                    end else begin
                        d.tmr = q.tmr + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign shutdown = (q.st == TL_DOWN);
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
    parameter int NUM_RAILS    = 5,
    parameter int QUIET_CYCLES = 16384,
    parameter int LIM_RESTART  = 4,
    parameter int LIM_NORMAL   = 5,
    parameter int FEED_SRC [NUM_RAILS] = '{0, 0, 2, 3, 4}
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 s5_clear,
    input  logic                 restart_s5,
    input  logic                 retry_go,
    input  logic [NUM_RAILS-1:0] uv_flag,
    input  logic [NUM_RAILS-1:0] oc_flag,
    output logic [NUM_RAILS-1:0] rail_disable,
    output logic                 retry_req,
    output logic                 shutdown
);
    logic [NUM_RAILS-1:0] ev;
    logic [NUM_RAILS-1:0] dis_q;
    logic                 down;

    fsup_event_gen #(
        .NUM_RAILS (NUM_RAILS),
        .FEED_SRC  (FEED_SRC)
    ) u_evt (
        .active  (~down),
        .uv_flag (uv_flag),
        .oc_flag (oc_flag),
        .dis_q   (dis_q),
        .ev      (ev)
    );

    fsup_rail_latch #(
        .NUM_RAILS (NUM_RAILS)
    ) u_latch (
        .clk         (clk),
        .rst         (rst),
        .clr         (s5_clear),
        .release_all (retry_go & ~down),
        .ev          (ev),
        .dis_q       (dis_q)
    );

    fsup_tally #(
        .NUM_RAILS    (NUM_RAILS),
        .QUIET_CYCLES (QUIET_CYCLES),
        .LIM_RESTART  (LIM_RESTART),
        .LIM_NORMAL   (LIM_NORMAL)
    ) u_tally (
        .clk        (clk),
        .rst        (rst),
        .clr        (s5_clear),
        .restart_s5 (restart_s5),
        .ev         (ev),
        .shutdown   (down)
    );

    assign rail_disable = dis_q | {NUM_RAILS{down}};
    assign retry_req    = (|dis_q) & ~down;
    assign shutdown     = down;
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk #(
    parameter int NUM_RAILS = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 s5_clear,
    input logic                 retry_go,
    input logic [NUM_RAILS-1:0] uv_flag,
    input logic [NUM_RAILS-1:0] oc_flag,
    input logic [NUM_RAILS-1:0] rail_disable,
    input logic                 retry_req,
    input logic                 shutdown
);
    // R10
    sd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        shutdown && !s5_clear |=> shutdown);

    // R10
    sd_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        shutdown |-> (!retry_req && (&rail_disable)));

    // R1
    clr_chk: assert property (@(posedge clk) disable iff (rst)
        s5_clear |=> (!shutdown && rail_disable == '0));

    // R9
    retry_release_chk: assert property (@(posedge clk) disable iff (rst)
        (retry_go && !shutdown && !s5_clear && uv_flag == '0 && oc_flag == '0)
        |=> (shutdown || ((rail_disable & $past(rail_disable)) == '0)));

    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_flag
        // R2
        flag_dis_chk: assert property (@(posedge clk) disable iff (rst)
            ((uv_flag[i] || oc_flag[i]) && !retry_go && !s5_clear) |=> rail_disable[i]);
    end
endmodule

bind fault_supervisor fault_supervisor_chk #(.NUM_RAILS(NUM_RAILS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .s5_clear     (s5_clear),
    .retry_go     (retry_go),
    .uv_flag      (uv_flag),
    .oc_flag      (oc_flag),
    .rail_disable (rail_disable),
    .retry_req    (retry_req),
    .shutdown     (shutdown)
);

// File: tb/fault_supervisor_tb.sv
module fault_supervisor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 5;
    localparam int WATCHDOG   = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         s5_clear = 1'b0;
    logic         restart_s5 = 1'b0;
    logic         retry_go = 1'b0;
    logic [N-1:0] uv_flag = '0;
    logic [N-1:0] oc_flag = '0;
    logic [N-1:0] rail_disable;
    logic         retry_req;
    logic         shutdown;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_supervisor u_dut (
        .clk          (clk),
        .rst          (rst),
        .s5_clear     (s5_clear),
        .restart_s5   (restart_s5),
        .retry_go     (retry_go),
        .uv_flag      (uv_flag),
        .oc_flag      (oc_flag),
        .rail_disable (rail_disable),
        .retry_req    (retry_req),
        .shutdown     (shutdown)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one-cycle flag pulse; returns at the negedge after the counting edge
    task automatic pulse(input logic [N-1:0] uv, input logic [N-1:0] oc);
        @(negedge clk);
        uv_flag = uv;
        oc_flag = oc;
        @(negedge clk);
        uv_flag = '0;
        oc_flag = '0;
    endtask

    task automatic do_retry();
        @(negedge clk);
        retry_go = 1'b1;
        @(negedge clk);
        retry_go = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        s5_clear = 1'b1;
        @(negedge clk);
        s5_clear = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset disable", 32'(rail_disable), 32'h0);
        check("R1 reset retry", 32'(retry_req), 32'h0);
        check("R1 reset shutdown", 32'(shutdown), 32'h0);
    endtask

    task automatic t_single_and_multi();
        do_clear();
        pulse(5'b01000, 5'b01000);
        check("R2 only rail3 off", 32'(rail_disable), 32'h08);
        check("R9 retry requested", 32'(retry_req), 32'h1);
        pulse(5'b10110, 5'b00000);
        check("R5 three at once total 4", 32'(shutdown), 32'h0);
        pulse(5'b00001, 5'b00000);
        check("R6 shutdown at fifth", 32'(shutdown), 32'h1);
        check("R10 all rails off", 32'(rail_disable), 32'h1f);
        check("R10 no retry in shutdown", 32'(retry_req), 32'h0);
    endtask

    task automatic t_restart_limit();
        do_clear();
        check("R1 clear releases", 32'({shutdown, rail_disable}), 32'h0);
        restart_s5 = 1'b1;
        pulse(5'b01100, 5'b00000);
        pulse(5'b10000, 5'b00000);
        check("R7 three below restart limit", 32'(shutdown), 32'h0);
        pulse(5'b00000, 5'b00010);
        check("R7 shutdown at fourth", 32'(shutdown), 32'h1);
        restart_s5 = 1'b0;
        do_clear();
        pulse(5'b11110, 5'b00000);
        check("R5 four at once counts 4", 32'(shutdown), 32'h0);
        do_clear();
        restart_s5 = 1'b1;
        pulse(5'b11110, 5'b00000);
        check("R7 R5 four at once hits restart limit", 32'(shutdown), 32'h1);
        restart_s5 = 1'b0;
    endtask

    task automatic t_cascade();
        do_clear();
        pulse(5'b00001, 5'b00000);
        check("R4 parent off first", 32'(rail_disable), 32'h01);
        @(negedge clk);
        check("R4 fed rail follows", 32'(rail_disable), 32'h03);
        pulse(5'b01100, 5'b00000);
        check("R4 tally 4 no shutdown", 32'(shutdown), 32'h0);
        pulse(5'b10000, 5'b00000);
        check("R4 cascade counted", 32'(shutdown), 32'h1);
    endtask

    task automatic t_ignored();
        do_clear();
        pulse(5'b00100, 5'b00000);
        @(negedge clk);
        uv_flag = 5'b00100;
        repeat (8) @(negedge clk);
        uv_flag = '0;
        check("R3 held flag ignored", 32'(shutdown), 32'h0);
        check("R3 only rail2 off", 32'(rail_disable), 32'h04);
        pulse(5'b11000, 5'b00000);
        pulse(5'b00010, 5'b00000);
        check("R3 tally 4", 32'(shutdown), 32'h0);
        pulse(5'b00001, 5'b00000);
        check("R3 tally 5", 32'(shutdown), 32'h1);
    endtask

    task automatic t_retry();
        do_clear();
        pulse(5'b00100, 5'b00000);
        for (int k = 0; k < 3; k++) begin
            do_retry();
            check("R9 release clears disables", 32'(rail_disable), 32'h0);
            check("R9 release drops request", 32'(retry_req), 32'h0);
            pulse(5'b00100, 5'b00000);
        end
        check("R9 tally kept at 4", 32'(shutdown), 32'h0);
        do_retry();
        pulse(5'b00100, 5'b00000);
        check("R9 fifth after retries", 32'(shutdown), 32'h1);
        do_retry();
        check("R10 retry ignored", 32'({retry_req, shutdown, rail_disable}), 32'h3f);
        pulse(5'b11111, 5'b11111);
        check("R10 flags ignored", 32'({retry_req, shutdown, rail_disable}), 32'h3f);
        do_clear();
        check("R1 clear after shutdown", 32'({retry_req, shutdown, rail_disable}), 32'h0);
    endtask

    task automatic t_decay();
        do_clear();
        pulse(5'b11110, 5'b00000);
        repeat (16382) @(negedge clk);
        pulse(5'b00001, 5'b00000);
        check("R8 inside window kept", 32'(shutdown), 32'h1);
        do_clear();
        pulse(5'b11110, 5'b00000);
        repeat (16384) @(negedge clk);
        pulse(5'b00001, 5'b00000);
        check("R8 outside window cleared", 32'(shutdown), 32'h0);
        @(negedge clk);
        check("R8 still no shutdown", 32'(shutdown), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single_and_multi();
        t_restart_limit();
        t_cascade();
        t_ignored();
        t_retry();
        t_decay();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule